// File: doc/BRIEF.md
# UART Host Register Decoder

This block is the host-side register front end of a 16550-compatible serial port. A host issues single-byte reads and writes on a 3-bit offset bus. The block decodes them into the line control register, a scratch register, the FIFO control register and the 16-bit baud divisor. When the divisor-access bit of the line control register is set, offsets 0 and 1 address the divisor bytes rather than the data port.

The receive FIFO storage, the serializer and the baud generator sit outside this block. It drives them through simple ports:
- push, pop, flush and resize strobes go to the FIFO;
- the FIFO's occupancy and full flag come back in;
- the divisor, line control and FIFO control values are presented as outputs.

A read of the line status offset builds the status byte from the FIFO occupancy and a sticky overrun flag. The transmitter is reported as permanently ready.

Top module: `uart_host_regs`

## Requirements
- R1: While bit 7 of the line control register is 1, offset 0 reads and writes the low divisor byte and offset 1 the high divisor byte. While it is 0, offset 0 is the data port and offset 1 holds no register.
- R2: After reset the divisor is 1, derived as 1843200 / 115200 / 16, with its high byte 0. The line control, scratch and FIFO control registers and the overrun flag are 0.
- R3: A write to offset 2 whose bit 0 differs from the stored FIFO-enable bit pulses `fifoFlush` and `fifoResize` in that cycle. `fifoDepthFull` equals the new bit 0: 1 selects the full FIFO depth and 0 a single entry.
- R4: A write to offset 2 with bit 0 clear stores 0 in the FIFO control register. With bit 0 set, only bits 0, 3, 6 and 7 are kept (mask 0xC9).
- R5: A write to offset 2 with bits 0 and 1 both set pulses `fifoFlush`, even when the enable bit does not change.
- R6: A read of offset 5 returns bits 6 and 5 as 1 and bit 0 as 1 exactly when `fifoCount` is non-zero. Bits 7, 4, 3 and 2 return 0.
- R7: A data write while `fifoFull` is 1 sets the overrun flag, which is bit 1 of the offset-5 byte. The offset-5 read that returns the flag clears it.
- R8: Writes to offsets 4, 5 and 6, and writes to offset 1 while bit 7 of the line control register is 0, change no register.
- R9: Reads of offsets 2, 4 and 6, and of offset 1 while bit 7 of the line control register is 0, return 0xFF.
- R10: Offset 7 is an 8-bit scratch register and offset 3 the fully writable line control register, both read back unchanged.
- R11: Read data appears on `rdData` one clock after `rdStb`. A data read pulses `popStb` and returns `popData`. A data write pulses `pushStb` with `pushData` equal to the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStb | input | 1 | Host read strobe |
| wrStb | input | 1 | Host write strobe |
| regAddr | input | 3 | Register offset |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Registered read byte |
| fifoCount | input | 5 | Receive FIFO occupancy |
| fifoFull | input | 1 | Receive FIFO is full |
| popData | input | 8 | Receive FIFO head byte |
| popStb | output | 1 | Remove head byte from FIFO |
| pushStb | output | 1 | Append byte to FIFO |
| pushData | output | 8 | Byte to append |
| fifoFlush | output | 1 | Empty the receive FIFO |
| fifoResize | output | 1 | Load new FIFO depth |
| fifoDepthFull | output | 1 | New depth: 1 full, 0 single entry |
| divisor | output | 16 | Baud divisor |
| lineCtrl | output | 8 | Line control register |
| fifoCtrl | output | 8 | FIFO control register |

## Verification
Directed cases come first:
- the reset values;
- the divisor-access redirection;
- the unmapped 0xFF reads;
- an overrun raised by writing into a single-entry FIFO, then cleared by two consecutive status reads.

A fixed-seed random stream of reads and writes across all eight offsets then toggles the divisor-access bit and the FIFO enable and reset bits at arbitrary points. A bench FIFO model reacts to the block's strobes. Against it, the random stream separates flushes caused by a change of enable from those requested by the receiver-reset bit, and it shows whether data-ready follows the FIFO occupancy through pushes, pops and flushes.

// File: rtl/uart_host_regs_pkg.sv
package uart_host_regs_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_FCTL = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4;
  localparam logic [2:0] OFS_LSTS = 3'd5;
  localparam logic [2:0] OFS_MSTS = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [7:0] FCTL_KEEP = 8'hC9;

  typedef enum logic [2:0] {
    SRC_FIFO, SRC_DIVLO, SRC_DIVHI, SRC_LCTL, SRC_LSTS, SRC_SCR, SRC_ONES
  } rdSrcE;

  typedef struct packed {
    logic  wrDivLo;
    logic  wrDivHi;
    logic  wrLctl;
    logic  wrScr;
    logic  wrFctl;
    logic  wrTx;
    logic  rdEn;
    rdSrcE rdSrc;
  } regStbS;

endpackage

// File: rtl/uart_host_regs_ctrl.sv
module uart_host_regs_ctrl
  import uart_host_regs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              dlab,
  output regStbS            stb
);

  always_comb begin
    stb = '0;
    stb.rdSrc = SRC_ONES;
    stb.rdEn  = rdStb;
    if (wrStb) begin
      unique case (regAddr)
        OFS_DATA: if (dlab) stb.wrDivLo = 1'b1; else stb.wrTx = 1'b1;
        OFS_IEN:  if (dlab) stb.wrDivHi = 1'b1;
        OFS_FCTL: stb.wrFctl = 1'b1;
        OFS_LCTL: stb.wrLctl = 1'b1;
        OFS_SCR:  stb.wrScr  = 1'b1;
        default:  ;
      endcase
    end
    unique case (regAddr)
      OFS_DATA: stb.rdSrc = dlab ? SRC_DIVLO : SRC_FIFO;
      OFS_IEN:  stb.rdSrc = dlab ? SRC_DIVHI : SRC_ONES;
      OFS_LCTL: stb.rdSrc = SRC_LCTL;
      OFS_LSTS: stb.rdSrc = SRC_LSTS;
      OFS_SCR:  stb.rdSrc = SRC_SCR;
      default:  stb.rdSrc = SRC_ONES;
    endcase
  end

  // R8: writes to status/modem offsets raise no write strobe
  a_r8_no_strobe_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && (regAddr == OFS_LSTS || regAddr == OFS_MSTS || regAddr == OFS_MCTL))
    |-> !(stb.wrDivLo | stb.wrDivHi | stb.wrLctl | stb.wrScr | stb.wrFctl | stb.wrTx));

  // R1: data and divisor strobes are exclusive
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrDivLo, stb.wrDivHi, stb.wrLctl, stb.wrScr, stb.wrFctl, stb.wrTx}));

endmodule

// File: rtl/uart_host_regs_dp.sv
module uart_host_regs_dp
  import uart_host_regs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 5,
  parameter int RESET_DIV = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStbS              stb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [CNT_W-1:0]    fifoCount,
  input  logic                fifoFull,
  input  logic [DATA_W-1:0]   popData,
  output logic                popStb,
  output logic                pushStb,
  output logic [DATA_W-1:0]   pushData,
  output logic                fifoFlush,
  output logic                fifoResize,
  output logic                fifoDepthFull,
  output logic [2*DATA_W-1:0] divisor,
  output logic [DATA_W-1:0]   lineCtrl,
  output logic [DATA_W-1:0]   fifoCtrl
);

  localparam int DIV_W = 2 * DATA_W;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RESET_DIV);

  logic [DATA_W-1:0] divLoQ, divHiQ, lctlQ, scrQ, fctlQ;
  logic              overrunQ;
  logic              enChange, overrunSet, lstsRead;
  logic [DATA_W-1:0] lstsByte, rdNext, fctlNext;

  assign enChange      = stb.wrFctl && (wrData[0] != fctlQ[0]);
  assign fifoResize    = enChange;
  assign fifoDepthFull = wrData[0];
  assign fifoFlush     = enChange || (stb.wrFctl && wrData[0] && wrData[1]);
  assign pushStb       = stb.wrTx;
  assign pushData      = wrData;
  assign popStb        = stb.rdEn && (stb.rdSrc == SRC_FIFO);
  assign overrunSet    = stb.wrTx && fifoFull;
  assign lstsRead      = stb.rdEn && (stb.rdSrc == SRC_LSTS);
  assign fctlNext      = wrData[0] ? (wrData & FCTL_KEEP) : '0;

  always_comb begin
    lstsByte    = '0;
    lstsByte[0] = (fifoCount != '0);
    lstsByte[1] = overrunQ;
    lstsByte[5] = 1'b1;
    lstsByte[6] = 1'b1;
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_FIFO:  rdNext = popData;
      SRC_DIVLO: rdNext = divLoQ;
      SRC_DIVHI: rdNext = divHiQ;
      SRC_LCTL:  rdNext = lctlQ;
      SRC_LSTS:  rdNext = lstsByte;
      SRC_SCR:   rdNext = scrQ;
      default:   rdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLoQ   <= DIV_INIT[DATA_W-1:0];
      divHiQ   <= DIV_INIT[DIV_W-1:DATA_W];
      lctlQ    <= '0;
      scrQ     <= '0;
      fctlQ    <= '0;
      overrunQ <= 1'b0;
      rdData   <= '0;
    end else begin
      if (stb.wrDivLo) divLoQ <= wrData;
      if (stb.wrDivHi) divHiQ <= wrData;
      if (stb.wrLctl)  lctlQ  <= wrData;
      if (stb.wrScr)   scrQ   <= wrData;
      if (stb.wrFctl)  fctlQ  <= fctlNext;
      overrunQ <= overrunSet | (overrunQ & ~lstsRead);
      if (stb.rdEn)    rdData <= rdNext;
    end
  end

  assign divisor  = {divHiQ, divLoQ};
  assign lineCtrl = lctlQ;
  assign fifoCtrl = fctlQ;

  // R4: disabled FIFO control stores zero
  a_r4_fctl_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.wrFctl && !wrData[0]) |-> (fifoCtrl == '0));

  // R5: receiver reset with enable flushes
  a_r5_rcv_flush: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrFctl && wrData[0] && wrData[1]) |-> fifoFlush);

  // R6: transmitter always ready on a status read
  a_r6_tx_ready: assert property (@(posedge clk) disable iff (!rstN)
    $past(lstsRead) |-> (rdData[6:5] == 2'b11 && rdData[7] == 1'b0));

  // R7: overrun set by a full write, cleared by a status read
  a_r7_oe_set: assert property (@(posedge clk) disable iff (!rstN)
    $past(overrunSet) |-> overrunQ);
  a_r7_oe_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(lstsRead && !overrunSet) |-> !overrunQ);

  // R9: unmapped reads return all ones
  a_r9_ones: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.rdEn && stb.rdSrc == SRC_ONES) |-> (rdData == '1));

  // R3: resize follows any change of the enable bit
  a_r3_resize_flush: assert property (@(posedge clk) disable iff (!rstN)
    fifoResize |-> fifoFlush);

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_regs_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int REF_HZ     = 1843200,
  parameter int BAUD       = 115200,
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int RESET_DIV = REF_HZ / BAUD / OVERSAMPLE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdStb,
  input  logic                wrStb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [CNT_W-1:0]    fifoCount,
  input  logic                fifoFull,
  input  logic [DATA_W-1:0]   popData,
  output logic                popStb,
  output logic                pushStb,
  output logic [DATA_W-1:0]   pushData,
  output logic                fifoFlush,
  output logic                fifoResize,
  output logic                fifoDepthFull,
  output logic [2*DATA_W-1:0] divisor,
  output logic [DATA_W-1:0]   lineCtrl,
  output logic [DATA_W-1:0]   fifoCtrl
);

  regStbS stb;

  uart_host_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb),
    .regAddr(regAddr), .dlab(lineCtrl[DATA_W-1]), .stb(stb)
  );

  uart_host_regs_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_DIV(RESET_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdData(rdData),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .popData(popData),
    .popStb(popStb), .pushStb(pushStb), .pushData(pushData),
    .fifoFlush(fifoFlush), .fifoResize(fifoResize), .fifoDepthFull(fifoDepthFull),
    .divisor(divisor), .lineCtrl(lineCtrl), .fifoCtrl(fifoCtrl)
  );

endmodule

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStb = 1'b0, wrStb = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, popData, pushData, lineCtrl, fifoCtrl;
  logic [4:0] fifoCount;
  logic fifoFull, popStb, pushStb, fifoFlush, fifoResize, fifoDepthFull;
  logic [15:0] divisor;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench FIFO model
  int cnt = 0, cap = 1;
  assign fifoCount = 5'(cnt);
  assign fifoFull  = (cnt == cap);
  assign popData   = 8'hA0 | 8'(cnt[3:0]);

  // register mirror
  logic [7:0] mLcr, mScr, mFcr, mLo, mHi;
  bit mOe;

  always #4 clk = ~clk;

  uart_host_regs u_dut (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .fifoCount(fifoCount), .fifoFull(fifoFull),
    .popData(popData), .popStb(popStb), .pushStb(pushStb), .pushData(pushData),
    .fifoFlush(fifoFlush), .fifoResize(fifoResize), .fifoDepthFull(fifoDepthFull),
    .divisor(divisor), .lineCtrl(lineCtrl), .fifoCtrl(fifoCtrl)
  );

  always @(posedge clk) begin
    if (fifoResize) cap <= fifoDepthFull ? 16 : 1;
    if (fifoFlush) cnt <= 0;
    else if (pushStb && cnt < cap) cnt <= cnt + 1;
    else if (popStb && cnt > 0) cnt <= cnt - 1;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [2:0] a);
    bit dl = mLcr[7];
    case (a)
      3'd0: return dl ? mLo : (8'hA0 | 8'(cnt[3:0]));
      3'd1: return dl ? mHi : 8'hFF;
      3'd3: return mLcr;
      3'd5: return {1'b0, 2'b11, 3'b000, mOe, cnt != 0};
      3'd7: return mScr;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic doWrite(logic [2:0] a, logic [7:0] d);
    bit chg, rst;
    @(negedge clk);
    regAddr = a; wrData = d; wrStb = 1'b1;
    #1;
    if (a == 3'd2) begin
      chg = (d[0] != mFcr[0]);
      rst = d[0] && d[1];
      check("R3 resize", {15'd0, fifoResize}, {15'd0, chg});
      check("R3/R5 flush", {15'd0, fifoFlush}, {15'd0, chg || rst});
      if (chg) check("R3 depth", {15'd0, fifoDepthFull}, {15'd0, d[0]});
      mFcr = d[0] ? (d & 8'hC9) : 8'h00;
    end
    if (a == 3'd0 && !mLcr[7]) begin
      check("R11 push", {7'd0, pushStb, pushData}, {7'd0, 1'b1, d});
      if (cnt == cap) mOe = 1;
    end else begin
      check("R11 no push", {15'd0, pushStb}, 16'd0);
    end
    case (a)
      3'd0: if (mLcr[7]) mLo = d;
      3'd1: if (mLcr[7]) mHi = d;
      3'd3: mLcr = d;
      3'd7: mScr = d;
      default: ;
    endcase
    @(posedge clk);
    #1 wrStb = 1'b0;
    check("R1/R2/R8 divisor", divisor, {mHi, mLo});
    check("R4/R8 fifoCtrl", {8'd0, fifoCtrl}, {8'd0, mFcr});
    check("R10/R8 lineCtrl", {8'd0, lineCtrl}, {8'd0, mLcr});
  endtask

  task automatic doRead(logic [2:0] a, string req);
    logic [7:0] e;
    bit isPop;
    @(negedge clk);
    regAddr = a; rdStb = 1'b1;
    #1;
    e = expRead(a);
    isPop = (a == 3'd0 && !mLcr[7]);
    check("R11 pop", {15'd0, popStb}, {15'd0, isPop});
    if (a == 3'd5) mOe = 0;
    @(posedge clk);
    #1 rdStb = 1'b0;
    check(req, {8'd0, rdData}, {8'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1d5c;
    logic [2:0] a;
    logic [7:0] d;
    mLcr = 0; mScr = 0; mFcr = 0; mLo = 8'd1; mHi = 0; mOe = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R2: reset state
    check("R2 divisor", divisor, 16'd1);
    check("R2 lineCtrl", {8'd0, lineCtrl}, 16'd0);
    check("R2 fifoCtrl", {8'd0, fifoCtrl}, 16'd0);
    doRead(3'd7, "R2 scratch");
    doRead(3'd5, "R2/R6 status");
    // R9: unmapped offsets
    doRead(3'd1, "R9 offset1");
    doRead(3'd2, "R9 offset2");
    doRead(3'd4, "R9 offset4");
    doRead(3'd6, "R9 offset6");
    // R1: divisor access
    doWrite(3'd3, 8'h83);
    doRead(3'd0, "R1 div lo reset");
    doRead(3'd1, "R1 div hi reset");
    doWrite(3'd0, 8'h0C);
    doWrite(3'd1, 8'h5A);
    doRead(3'd0, "R1 div lo");
    doRead(3'd1, "R1 div hi");
    doWrite(3'd3, 8'h03);
    doWrite(3'd1, 8'h77);      // R8 ignored
    doRead(3'd1, "R8/R9 offset1");
    // R10 scratch
    doWrite(3'd7, 8'hC3);
    doRead(3'd7, "R10 scratch");
    // R7 overrun with single-entry FIFO
    doWrite(3'd0, 8'h11);
    doRead(3'd5, "R6 data ready");
    doWrite(3'd0, 8'h22);
    doRead(3'd5, "R7 overrun set");
    doRead(3'd5, "R7 overrun cleared");
    // R8 writes to status offsets
    doWrite(3'd5, 8'hFF);
    doWrite(3'd6, 8'hFF);
    doWrite(3'd4, 8'hFF);
    doRead(3'd5, "R8 status unchanged");
    doRead(3'd0, "R11 data pop");
    // R3/R4/R5 FIFO control
    doWrite(3'd2, 8'hFF);
    doWrite(3'd2, 8'h03);
    doWrite(3'd2, 8'h08);
    // random stream
    for (int i = 0; i < 600; i++) begin
      a = 3'($urandom(seed) % 8);
      seed = seed + 7;
      d = 8'($urandom(seed));
      seed = seed + 13;
      if (a == 3'd3 && d[7] && ($urandom(seed) % 2 == 0)) d[7] = 1'b0;
      if ($urandom(seed + i) % 2 == 0) doWrite(a, d);
      else doRead(a, "R6/R10/R11 random read");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule